// File: doc/BRIEF.md
# USB Slave-FIFO Bridge Master

This block sits in the FPGA next to a USB peripheral controller whose two endpoint buffers are reached through a slave FIFO port. The block is the master of that port. It watches the controller's status flags, selects an endpoint through a 2-bit FIFO address, controls the direction of the shared 16-bit data bus, and issues the read and write strobes itself. Words that the host sends arrive through the OUT endpoint and leave the block on a local receive stream. Words from a local transmit stream go into the IN endpoint.

The controller forwards IN data to the host only in whole packets of `PKT_BYTES` bytes. The block therefore counts the words of the current IN packet. If no real word arrives for `TIMEOUT` cycles while a packet is partly filled, it completes that packet with a fixed filler word so that the packet is still sent. A packet holding no words is never padded. A counter output reports how many filler words have been written.

The block serves one endpoint at a time. It stays on that endpoint while words can move, and it changes over only when the current direction stalls and the other direction has work. Each change of address is followed by one quiet cycle. The controller always has one idle cycle to release the bus before the block drives it for a write.

Top module: `usb_fifo_bridge`

## Requirements
- R1: While reset is held and in the first cycle after it, both strobes and the controller output enable are low, the address is the OUT address (2'b00) and the pad counter reads zero.
- R2: The read strobe is high only when the OUT endpoint is not empty and `rx_space` is high. Each read strobe is a receive push whose `rx_data` is the bus word, and the words arrive in bus order.
- R3: The write strobe is high only when the IN endpoint is not full and a word is ready. Real transmit words reach the bus in stream order, each exactly once, and `tx_take` is high only in a write-strobe cycle that carries a real word.
- R4: The controller output enable is high only while the OUT address (2'b00) is selected. The block drives the bus only while the IN address (2'b10) is selected. The two never overlap.
- R5: There is no write strobe in the cycle directly after a cycle in which the controller output enable was high.
- R6: The FIFO address changes only after a cycle with both strobes low, and both strobes stay low in the cycle right after the change.
- R7: When a packet is partly filled and no real word is written, padding starts after `TIMEOUT` cycles. With the IN endpoint not full, the first filler word is written exactly `TIMEOUT`+1 clock edges after the edge that wrote the last real word.
- R8: While padding, the block writes only `PAD_WORD` and holds back real words until the packet is complete, so the total IN word count is a whole number of packets.
- R9: Every real word restarts the timeout. Real words spaced at most `TIMEOUT` edges apart never cause padding.
- R10: When the IN word count is on a packet boundary, no filler word is written, however long the transmit stream stays idle.
- R11: `pad_count` goes up by exactly one for every filler word written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock shared with the controller |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_data | inout | DATA_W | Shared bidirectional data bus |
| fifo_addr | output | 2 | Endpoint select (00 OUT, 10 IN) |
| fifo_rd | output | 1 | Read strobe, active high |
| fifo_wr | output | 1 | Write strobe, active high |
| fifo_oe | output | 1 | Lets the controller drive the bus |
| in_full | input | 1 | IN endpoint full flag |
| out_empty | input | 1 | OUT endpoint empty flag |
| tx_valid | input | 1 | Transmit word available |
| tx_data | input | DATA_W | Transmit word |
| tx_take | output | 1 | Transmit word consumed this cycle |
| rx_space | input | 1 | Receive side can accept a word |
| rx_push | output | 1 | Receive word valid this cycle |
| rx_data | output | DATA_W | Receive word |
| pad_count | output | PADCNT_W | Number of filler words written |

## Verification
A wrong packet word count is not visible at once. It appears one timeout later, either as filler words that leave the IN total off a packet boundary or as filler written when the count is already on a boundary. A wrong phase or address register shows up in the same cycle: a strobe under the wrong address, the output enable next to a drive, or a strobe beside an address change. A timer that fails to restart moves the first filler word off its exact edge, so the bench measures that edge and keeps its own count of filler words.

// File: rtl/ufb_pkg.sv
package ufb_pkg;

  typedef enum logic [1:0] {
    PH_SETTLE = 2'd0,
    PH_READ   = 2'd1,
    PH_WRITE  = 2'd2
  } phase_e;

  // words per packet for a bus of the given width
  function automatic int pkt_words(input int bytes, input int width);
    return (bytes * 8) / width;
  endfunction

endpackage

// File: rtl/ufb_bus_seq.sv
module ufb_bus_seq #(
  parameter int ADDR_W = 2,
  parameter logic [ADDR_W-1:0] ADDR_OUT = 2'b00,
  parameter logic [ADDR_W-1:0] ADDR_IN  = 2'b10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_full,
  input  logic              out_empty,
  input  logic              rx_space,
  input  logic              word_avail,
  output logic [ADDR_W-1:0] fifo_addr,
  output logic              rd_stb,
  output logic              wr_stb,
  output logic              ctl_oe,
  output logic              bus_drive
);
  import ufb_pkg::*;

  phase_e            phase_q;
  logic [ADDR_W-1:0] addr_q;

  // named events for assertions and for the next-state logic
  logic can_rd, can_wr, go_in, go_out;

  assign can_rd = !out_empty && rx_space;
  assign can_wr = !in_full && word_avail;

  assign rd_stb    = (phase_q == PH_READ)  && can_rd;
  assign wr_stb    = (phase_q == PH_WRITE) && can_wr;
  assign ctl_oe    = (phase_q == PH_READ);
  assign bus_drive = (phase_q == PH_WRITE);
  assign fifo_addr = addr_q;

  assign go_in  = (phase_q == PH_READ)  && !can_rd && word_avail;
  assign go_out = (phase_q == PH_WRITE) && !can_wr && can_rd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_SETTLE;
      addr_q  <= ADDR_OUT;
    end else begin
      case (phase_q)
        PH_SETTLE: phase_q <= (addr_q == ADDR_OUT) ? PH_READ : PH_WRITE;
        PH_READ: if (go_in) begin
          addr_q  <= ADDR_IN;
          phase_q <= PH_SETTLE;
        end
        PH_WRITE: if (go_out) begin
          addr_q  <= ADDR_OUT;
          phase_q <= PH_SETTLE;
        end
        default: phase_q <= PH_SETTLE;
      endcase
    end
  end

  AST_RD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |-> (!out_empty && rx_space && fifo_addr == ADDR_OUT)); // R2
  AST_WR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (!in_full && fifo_addr == ADDR_IN)); // R3
  AST_BUS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl_oe && bus_drive)); // R4
  AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctl_oe) |-> !wr_stb); // R5
  AST_ADDR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_addr != $past(fifo_addr)) |->
      (!$past(rd_stb) && !$past(wr_stb) && !rd_stb && !wr_stb)); // R6

endmodule

// File: rtl/ufb_tx_packer.sv
module ufb_tx_packer #(
  parameter int DATA_W    = 16,
  parameter int PKT_WORDS = 256,
  parameter int TIMEOUT   = 4096,
  parameter logic [DATA_W-1:0] PAD_WORD = '0,
  parameter int PADCNT_W  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_fire,
  input  logic                tx_valid,
  input  logic [DATA_W-1:0]   tx_data,
  output logic                word_avail,
  output logic [DATA_W-1:0]   wr_word,
  output logic                tx_take,
  output logic [PADCNT_W-1:0] pad_count
);
  localparam int CNT_W = (PKT_WORDS > 2) ? $clog2(PKT_WORDS) : 1;
  localparam int TMR_W = $clog2(TIMEOUT + 1);
  localparam logic [CNT_W-1:0] LAST_IDX  = CNT_W'(PKT_WORDS - 1);
  localparam logic [TMR_W-1:0] TMR_LIMIT = TMR_W'(TIMEOUT - 1);

  function automatic logic [CNT_W-1:0] cnt_step(input logic [CNT_W-1:0] c);
    return (c == LAST_IDX) ? '0 : c + 1'b1;
  endfunction

  logic [CNT_W-1:0]    cnt_q;
  logic [TMR_W-1:0]    tmr_q;
  logic                pad_q;
  logic [PADCNT_W-1:0] padcnt_q;

  // named events
  logic pkt_open, timeout_hit, pad_fire, pkt_close;

  assign pkt_open    = (cnt_q != '0);
  assign tx_take     = wr_fire && !pad_q;
  assign pad_fire    = wr_fire && pad_q;
  assign pkt_close   = wr_fire && (cnt_q == LAST_IDX);
  assign timeout_hit = pkt_open && !pad_q && !tx_take && (tmr_q == TMR_LIMIT);

  assign word_avail = pad_q || tx_valid;
  assign wr_word    = pad_q ? PAD_WORD : tx_data;
  assign pad_count  = padcnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      tmr_q    <= '0;
      pad_q    <= 1'b0;
      padcnt_q <= '0;
    end else begin
      if (wr_fire) cnt_q <= cnt_step(cnt_q);

      if (!pkt_open || pad_q || tx_take) tmr_q <= '0;
      else if (!timeout_hit)             tmr_q <= tmr_q + 1'b1;

      if (timeout_hit)                pad_q <= 1'b1;
      else if (pad_fire && pkt_close) pad_q <= 1'b0;

      if (pad_fire) padcnt_q <= padcnt_q + 1'b1;
    end
  end

  AST_PAD_ONLY_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    pad_q |-> pkt_open); // R10
  AST_PAD_ENDS_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pad_q) |-> (cnt_q == '0)); // R8
  AST_PAD_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pad_fire) |-> (padcnt_q == $past(padcnt_q) + 1'b1)); // R11
  AST_PAD_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(pad_fire) |-> $stable(padcnt_q)); // R11

endmodule

// File: rtl/usb_fifo_bridge.sv
module usb_fifo_bridge #(
  parameter int DATA_W    = 16,
  parameter int PKT_BYTES = 512,
  parameter int TIMEOUT   = 4096,
  parameter logic [DATA_W-1:0] PAD_WORD = '0,
  parameter int PADCNT_W  = 16,
  parameter logic [1:0] ADDR_OUT = 2'b00,
  parameter logic [1:0] ADDR_IN  = 2'b10
) (
  input  logic                clk,
  input  logic                rst_n,
  inout  wire  [DATA_W-1:0]   fifo_data,
  output logic [1:0]          fifo_addr,
  output logic                fifo_rd,
  output logic                fifo_wr,
  output logic                fifo_oe,
  input  logic                in_full,
  input  logic                out_empty,
  input  logic                tx_valid,
  input  logic [DATA_W-1:0]   tx_data,
  output logic                tx_take,
  input  logic                rx_space,
  output logic                rx_push,
  output logic [DATA_W-1:0]   rx_data,
  output logic [PADCNT_W-1:0] pad_count
);
  localparam int PKT_WORDS = ufb_pkg::pkt_words(PKT_BYTES, DATA_W);

  logic              word_avail;
  logic [DATA_W-1:0] wr_word;
  logic              rd_stb, wr_stb, ctl_oe, bus_drive;

  ufb_bus_seq #(
    .ADDR_W   (2),
    .ADDR_OUT (ADDR_OUT),
    .ADDR_IN  (ADDR_IN)
  ) seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_full    (in_full),
    .out_empty  (out_empty),
    .rx_space   (rx_space),
    .word_avail (word_avail),
    .fifo_addr  (fifo_addr),
    .rd_stb     (rd_stb),
    .wr_stb     (wr_stb),
    .ctl_oe     (ctl_oe),
    .bus_drive  (bus_drive)
  );

  ufb_tx_packer #(
    .DATA_W    (DATA_W),
    .PKT_WORDS (PKT_WORDS),
    .TIMEOUT   (TIMEOUT),
    .PAD_WORD  (PAD_WORD),
    .PADCNT_W  (PADCNT_W)
  ) pack_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_fire    (wr_stb),
    .tx_valid   (tx_valid),
    .tx_data    (tx_data),
    .word_avail (word_avail),
    .wr_word    (wr_word),
    .tx_take    (tx_take),
    .pad_count  (pad_count)
  );

  assign fifo_data = bus_drive ? wr_word : {DATA_W{1'bz}};
  assign fifo_rd   = rd_stb;
  assign fifo_wr   = wr_stb;
  assign fifo_oe   = ctl_oe;
  assign rx_push   = rd_stb;
  assign rx_data   = fifo_data;

  AST_TAKE_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_take |-> (fifo_wr && tx_valid)); // R3
  AST_OE_ON_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_oe |-> (fifo_addr == ADDR_OUT)); // R4

endmodule

// File: tb/usb_fifo_bridge_tb.sv
module usb_fifo_bridge_tb_top;
  localparam int PKTW = 4;
  localparam int TMO  = 6;
  localparam logic [15:0] PADW = 16'hA5A5;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  wire  [15:0] fdata;
  logic [1:0]  faddr;
  logic        frd, fwr, foe;
  logic        in_full, out_empty, tx_valid, rx_space;
  logic [15:0] tx_data;
  logic        tx_take, rx_push;
  logic [15:0] rx_data;
  logic [7:0]  pad_count;
  logic [15:0] out_word;

  assign fdata = foe ? out_word : 16'hzzzz;

  usb_fifo_bridge #(
    .DATA_W(16), .PKT_BYTES(PKTW * 2), .TIMEOUT(TMO),
    .PAD_WORD(PADW), .PADCNT_W(8)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .fifo_data(fdata), .fifo_addr(faddr),
    .fifo_rd(frd), .fifo_wr(fwr), .fifo_oe(foe), .in_full(in_full),
    .out_empty(out_empty), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_take(tx_take), .rx_space(rx_space), .rx_push(rx_push),
    .rx_data(rx_data), .pad_count(pad_count)
  );

  int checks = 0, errors = 0;
  int tx_left = 0, out_left = 0, tx_sent = 0, out_rcv = 0;
  int in_total = 0, pads_exp = 0, idle = 0, first_pad_idle = -1;
  int cyc = 0;
  bit tx_en = 0, rx_mode = 0, full_mode = 0, pad_run = 0, done = 0;
  bit prev_oe = 0, prev_rd = 0, prev_wr = 0;
  logic [1:0] prev_addr = 2'b00;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // per-cycle monitor (negedge) and input driver (just after posedge)
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (frd) begin
          chk(!out_empty && rx_space, "R2 read gating", 0, 1);
          chk(rx_push, "R2 push with read", 0, 1);
          chk(rx_data == 16'(16'h8000 + out_rcv), "R2 rx order", int'(rx_data), 16'h8000 + out_rcv);
          chk(foe && faddr == 2'b00, "R4 read under OUT address", int'(faddr), 0);
        end
        if (fwr) begin
          chk(!in_full, "R3 write gating", 1, 0);
          chk(!foe && faddr == 2'b10, "R4 write under IN address", int'(faddr), 2);
          if (tx_take) begin
            chk(fdata == 16'(16'h1000 + tx_sent), "R3 tx order", int'(fdata), 16'h1000 + tx_sent);
          end else begin
            chk(fdata == PADW, "R8 pad value", int'(fdata), int'(PADW));
            chk(idle >= TMO, "R7 pad not before timeout", idle, TMO);
            chk(in_total % PKTW != 0, "R10 no pad on boundary", in_total % PKTW, 1);
            if (!pad_run) first_pad_idle = idle;
          end
        end
        chk(!tx_take || fwr, "R3 take only with write", 1, 0);
        chk(!(prev_oe && fwr), "R5 turnaround", 1, 0);
        if (faddr != prev_addr)
          chk(!prev_rd && !prev_wr && !frd && !fwr, "R6 quiet address change", 1, 0);
        chk(pad_count == 8'(pads_exp), "R11 pad counter", int'(pad_count), pads_exp);
        if (frd) begin out_rcv++; out_left--; end
        if (fwr) begin
          in_total++;
          if (tx_take) begin tx_sent++; tx_left--; idle = 0; end
          else begin pads_exp++; pad_run = 1; idle++; end
          if (in_total % PKTW == 0) pad_run = 0;
        end else idle++;
        prev_oe = foe; prev_rd = frd; prev_wr = fwr; prev_addr = faddr;
      end
      @(posedge clk);
      #1;
      out_empty = (out_left == 0);
      out_word  = 16'(16'h8000 + out_rcv);
      tx_valid  = tx_en && (tx_left > 0);
      tx_data   = 16'(16'h1000 + tx_sent);
      rx_space  = rx_mode ? (cyc % 3 != 0) : 1'b1;
      in_full   = full_mode ? (cyc % 4 == 1) : 1'b0;
      cyc++;
    end
  end

  task automatic wait_drain();
    for (int i = 0; i < 2000; i++) begin
      if (tx_left == 0 && out_left == 0) break;
      @(posedge clk);
    end
    #2;
  endtask

  task automatic idle_cycles(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  initial begin
    rst_n = 1'b0; out_empty = 1'b1; tx_valid = 1'b0; tx_data = '0;
    rx_space = 1'b1; in_full = 1'b0; out_word = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!frd && !fwr, "R1 strobes in reset", int'(frd) + int'(fwr), 0);
    chk(!foe, "R1 oe in reset", int'(foe), 0);
    chk(faddr == 2'b00, "R1 address in reset", int'(faddr), 0);
    chk(pad_count == 0, "R1 pad counter in reset", int'(pad_count), 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!frd && !fwr && !foe, "R1 first cycle quiet", 1, 0);

    // OUT stream, open receiver then throttled receiver
    @(posedge clk); #2 out_left = 20;
    wait_drain();
    chk(out_rcv == 20, "R2 all OUT words", out_rcv, 20);
    rx_mode = 1; out_left = 15;
    wait_drain();
    chk(out_rcv == 35, "R2 throttled OUT words", out_rcv, 35);
    rx_mode = 0;

    // two whole packets: no padding ever
    tx_en = 1; tx_left = 8;
    wait_drain();
    idle_cycles(4 * TMO);
    chk(in_total == 8, "R3 whole packets written", in_total, 8);
    chk(pad_count == 0, "R10 no pad after whole packets", int'(pad_count), 0);

    // partial packet: exact timeout edge and fill
    tx_left = 3;
    wait_drain();
    idle_cycles(4 * TMO);
    chk(first_pad_idle == TMO, "R7 first pad edge", first_pad_idle, TMO);
    chk(pad_count == 1, "R8 pad fill count", int'(pad_count), 1);
    chk(in_total % PKTW == 0, "R8 packet closed", in_total % PKTW, 0);

    // spaced words inside the timeout: no padding
    for (int k = 0; k < 3; k++) begin
      tx_left = 1;
      wait_drain();
      idle_cycles(TMO - 3);
    end
    tx_left = 1;
    wait_drain();
    idle_cycles(4 * TMO);
    chk(pad_count == 1, "R9 timer restart", int'(pad_count), 1);
    chk(in_total % PKTW == 0, "R9 packet closed", in_total % PKTW, 0);

    // mixed traffic with full flag and receiver throttling
    full_mode = 1; rx_mode = 1;
    out_left = 30; tx_left = 13;
    wait_drain();
    idle_cycles(6 * TMO);
    chk(out_rcv == 65, "R2 mixed OUT words", out_rcv, 65);
    chk(tx_sent == 28, "R3 mixed tx words", tx_sent, 28);
    chk(in_total == tx_sent + pads_exp, "R8 IN total", in_total, tx_sent + pads_exp);
    chk(in_total % PKTW == 0, "R8 mixed boundary", in_total % PKTW, 0);
    chk(pad_count == 8'(pads_exp), "R11 mixed pad count", int'(pad_count), pads_exp);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual %0d expected %0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule